// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer operands of a RISC core. At any moment an instruction sees 32 architectural registers. Eight of them are globals that every procedure shares. The other 24 are a window into a larger circular file of physical registers, and a current-window pointer chooses which window is visible. The register file has two combinational read ports and one write port, which is what a three-operand instruction needs.

Window movement has its own controls and is not tied to call and return. A save step, or a trap, moves to a fresh window. A restore step moves back. Adjacent windows overlap, so the caller's outgoing argument registers become the callee's incoming registers without any copy. An invalid-window mask comes from outside the block. If a move targets a window marked in that mask, the pointer stays where it is and an overflow or underflow flag is raised so that a handler can spill or fill that window. The spill and fill themselves are done outside this block.

Top module: `regwin_file`

## Requirements
- R1: Architectural index 0 always reads as zero, and a write to index 0 changes nothing, including the same-cycle read of index 0.
- R2: Indices 1 to 7 are globals. They are one set of registers, seen unchanged from every window.
- R3: A write takes effect at the rising clock edge. A read of the index being written in the same cycle returns the new write data on either read port.
- R4: Index encoding is: 0–7 global, 8–15 out, 16–23 local, 24–31 in. A save step decrements the window pointer modulo the window count. After a save, in register 24+k shows the value that out register 8+k had before the save. A write in the same cycle as a move uses the window that was current before the move.
- R5: A restore step increments the window pointer modulo the window count. After a restore, out register 8+k shows the value that in register 24+k had before the restore.
- R6: Local registers 16–23 are private to each window. Writing a local in one window does not change the locals of any other window.
- R7: If a save or trap targets a window (pointer − 1) whose bit is set in the invalid mask, overflow is high in that cycle and the pointer does not move.
- R8: If a restore targets a window (pointer + 1) whose bit is set in the invalid mask, underflow is high in that cycle and the pointer does not move.
- R9: A trap moves the window exactly as a save does. When a save or trap is asserted together with a restore, the downward move takes priority and the restore is dropped. Overflow and underflow are never high together.
- R10: After reset the window pointer is 0 and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index to write |
| wr_data | input | DW | Write data |
| win_save | input | 1 | Save step (move to the next lower window) |
| win_restore | input | 1 | Restore step (move to the next higher window) |
| win_trap | input | 1 | Trap entry (allocates a fresh window like a save) |
| win_invalid | input | NWIN | Invalid-window mask, one bit per window |
| cur_win | output | log2(NWIN) | Current window pointer |
| win_overflow | output | 1 | A downward move was blocked by the mask |
| win_underflow | output | 1 | An upward move was blocked by the mask |

## Verification
The bench first walks the pointer through all eight windows with save steps and writes every non-zero index in each window with a value that encodes the window and the index. It then walks back with restore steps and reads all 32 indices in every window. This separates a correct overlap of outs and ins from an off-by-one window, and separates private locals from shared globals. Every write cycle also reads the written index, so a missing bypass is seen apart from a late write. Mask patterns placed just below and just above the current window exercise the blocked save, trap and restore cases and the priority between a save and a restore. A long pseudo-random mix of moves, writes and reads then runs against an arithmetic model of the index mapping.

// File: rtl/rwf_pkg.sv
`timescale 1ns/1ps
package rwf_pkg;
    localparam int GLOBAL_CNT = 8;
    localparam int WIN_SLOTS  = 16;
    localparam int ARCH_AW    = 5;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_DOWN = 2'd1,
        MV_UP   = 2'd2
    } win_move_e;
endpackage

// File: rtl/rwf_xlate.sv
`timescale 1ns/1ps
module rwf_xlate
    import rwf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW    = $clog2(NWIN),
    localparam int NPHYS = GLOBAL_CNT + NWIN * WIN_SLOTS,
    localparam int PAW   = $clog2(NPHYS)
) (
    input  logic [ARCH_AW-1:0] arch_idx,
    input  logic [CW-1:0]      win,
    output logic [PAW-1:0]     phys_idx
);
    reg_grp_e      grp;
    logic [CW-1:0] wsel;
    logic          slot_hi;

    always_comb begin
        grp     = reg_grp_e'(arch_idx[4:3]);
        wsel    = win;
        slot_hi = 1'b0;
        case (grp)
            GRP_OUT:   wsel    = win - CW'(1);
            GRP_LOCAL: slot_hi = 1'b1;
            default:   slot_hi = 1'b0;
        endcase
        if (grp == GRP_GLOBAL) begin
            phys_idx = PAW'(arch_idx[2:0]);
        end else begin
            phys_idx = PAW'(GLOBAL_CNT) + PAW'(wsel) * PAW'(WIN_SLOTS)
                     + PAW'({slot_hi, arch_idx[2:0]});
        end
    end
endmodule

// File: rtl/rwf_winctl.sv
`timescale 1ns/1ps
module rwf_winctl
    import rwf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic            restore,
    input  logic            trap,
    input  logic [NWIN-1:0] invalid,
    output logic [CW-1:0]   cwp,
    output logic            ovf,
    output logic            unf
);
    typedef struct packed {
        logic [CW-1:0] cwp;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] tgt_dn, tgt_up;
    win_move_e     mv;

    always_comb begin
        tgt_dn = st_q.cwp - CW'(1);
        tgt_up = st_q.cwp + CW'(1);
        mv     = MV_HOLD;
        ovf    = 1'b0;
        unf    = 1'b0;
        if (save || trap) begin
            if (invalid[tgt_dn]) ovf = 1'b1;
            else                 mv  = MV_DOWN;
        end else if (restore) begin
            if (invalid[tgt_up]) unf = 1'b1;
            else                 mv  = MV_UP;
        end
        st_d = st_q;
        case (mv)
            MV_DOWN: st_d.cwp = tgt_dn;
            MV_UP:   st_d.cwp = tgt_up;
            default: st_d.cwp = st_q.cwp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp = st_q.cwp;

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cwp == $past(cwp)));
    // R8
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> (cwp == $past(cwp)));
    // R4
    save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((save || trap) && !ovf) |=> (cwp == CW'($past(cwp) - CW'(1))));
    // R5
    restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !save && !trap && !unf) |=> (cwp == CW'($past(cwp) + CW'(1))));
    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));
endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
module regwin_file
    import rwf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NWIN = 8,
    localparam int CW    = $clog2(NWIN),
    localparam int NPHYS = GLOBAL_CNT + NWIN * WIN_SLOTS,
    localparam int PAW   = $clog2(NPHYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ARCH_AW-1:0] rd_a_idx,
    output logic [DW-1:0]      rd_a_data,
    input  logic [ARCH_AW-1:0] rd_b_idx,
    output logic [DW-1:0]      rd_b_data,
    input  logic               wr_en,
    input  logic [ARCH_AW-1:0] wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic               win_save,
    input  logic               win_restore,
    input  logic               win_trap,
    input  logic [NWIN-1:0]    win_invalid,
    output logic [CW-1:0]      cur_win,
    output logic               win_overflow,
    output logic               win_underflow
);
    localparam int NPORT = 3;
    localparam int WPORT = 2;

    typedef struct packed {
        logic [NPHYS-1:0][DW-1:0] regs;
    } st_t;

    st_t                st_d, st_q;
    logic [ARCH_AW-1:0] x_arch [NPORT];
    logic [PAW-1:0]     x_phys [NPORT];
    logic [DW-1:0]      rd_dat [WPORT];
    logic               wr_live;

    rwf_winctl #(.NWIN(NWIN)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .save    (win_save),
        .restore (win_restore),
        .trap    (win_trap),
        .invalid (win_invalid),
        .cwp     (cur_win),
        .ovf     (win_overflow),
        .unf     (win_underflow)
    );

    assign x_arch[0]     = rd_a_idx;
    assign x_arch[1]     = rd_b_idx;
    assign x_arch[WPORT] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        rwf_xlate #(.NWIN(NWIN)) u_xl (
            .arch_idx (x_arch[p]),
            .win      (cur_win),
            .phys_idx (x_phys[p])
        );
    end

    assign wr_live = wr_en && (wr_idx != '0);

    for (genvar p = 0; p < WPORT; p++) begin : g_rd
        always_comb begin
            if (x_arch[p] == '0)
                rd_dat[p] = '0;
            else if (wr_live && (wr_idx == x_arch[p]))
                rd_dat[p] = wr_data;
            else
                rd_dat[p] = st_q.regs[x_phys[p]];
        end
    end

    assign rd_a_data = rd_dat[0];
    assign rd_b_data = rd_dat[1];

    always_comb begin
        st_d = st_q;
        if (wr_live) st_d.regs[x_phys[WPORT]] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    gzero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[0] == '0);
    // R3
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> (st_q.regs[$past(x_phys[WPORT])] == $past(wr_data)));
endmodule

// File: tb/sim_regwin_file.sv
`timescale 1ns/1ps
module sim_regwin_file;
    localparam int NW = 8;
    localparam int NP = 8 + NW * 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, win_save = 1'b0, win_restore = 1'b0, win_trap = 1'b0;
    logic [NW-1:0] win_invalid = '0;
    logic [2:0]  cur_win;
    logic        win_overflow, win_underflow;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [NP];
    int mcwp = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    regwin_file #(.DW(32), .NWIN(NW)) u0 (
        .clk, .rst_n, .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
        .wr_en, .wr_idx, .wr_data, .win_save, .win_restore, .win_trap,
        .win_invalid, .cur_win, .win_overflow, .win_underflow
    );

    function automatic int pmap(int idx, int w);
        if (idx < 8)  return idx;
        if (idx < 16) return 8 + ((w + NW - 1) % NW) * 16 + (idx - 8);
        if (idx < 24) return 8 + w * 16 + 8 + (idx - 16);
        return 8 + w * 16 + (idx - 24);
    endfunction

    function automatic logic [31:0] exp_rd(int idx, bit we, int wi, logic [31:0] wd);
        if (idx == 0) return 32'h0;
        if (we && wi == idx) return wd;
        return mdl[pmap(idx, mcwp)];
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(bit sv, bit rs, bit tp, bit we, int wi, logic [31:0] wd,
                       int ra, int rb, logic [NW-1:0] inv, string tag);
        bit dn, e_ovf, e_unf;
        int nxt;
        @(negedge clk);
        win_save = sv; win_restore = rs; win_trap = tp;
        wr_en = we; wr_idx = 5'(wi); wr_data = wd;
        rd_a_idx = 5'(ra); rd_b_idx = 5'(rb); win_invalid = inv;
        #1;
        chk(tag, "rd_a", rd_a_data, exp_rd(ra, we, wi, wd));
        chk(tag, "rd_b", rd_b_data, exp_rd(rb, we, wi, wd));
        dn = sv || tp;
        e_ovf = dn && inv[(mcwp + NW - 1) % NW];
        e_unf = !dn && rs && inv[(mcwp + 1) % NW];
        chk(tag, "overflow", 32'(win_overflow), 32'(e_ovf));
        chk(tag, "underflow", 32'(win_underflow), 32'(e_unf));
        nxt = mcwp;
        if (dn && !e_ovf) nxt = (mcwp + NW - 1) % NW;
        else if (!dn && rs && !e_unf) nxt = (mcwp + 1) % NW;
        @(posedge clk);
        if (we && wi != 0) mdl[pmap(wi, mcwp)] = wd;
        mcwp = nxt;
        #1;
        chk(tag, "cur_win", 32'(cur_win), 32'(mcwp));
    endtask

    task automatic rd(int ra, int rb, string tag);
        cyc(0, 0, 0, 0, 0, 32'h0, ra, rb, '0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "cur_win after reset", 32'(cur_win), 32'h0);
        for (int i = 0; i < 16; i++) rd(2 * i, 2 * i + 1, "R10");

        // R1: write to index 0 is dropped, even for the same-cycle read
        cyc(0, 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, '0, "R1");
        rd(0, 0, "R1");

        // Fill every window while stepping down; bypass exercised each write (R3)
        for (int w = 0; w < NW; w++) begin
            for (int i = 1; i < 31; i++)
                cyc(0, 0, 0, 1, i, 32'hA000_0000 + 32'(mcwp * 256 + i), i, (i * 7) % 32, '0, "R3");
            // write landing in the pre-move window (R4)
            cyc(1, 0, 0, 1, 31, 32'hB000_0000 + 32'(mcwp), 31, 8, '0, "R4");
        end

        // R4: out 8+3 becomes in 24+3 after a save
        cyc(0, 0, 0, 1, 11, 32'hC0DE_0011, 11, 27, '0, "R4");
        cyc(1, 0, 0, 0, 0, 32'h0, 27, 11, '0, "R4");
        rd(27, 19, "R4");

        // R5/R6/R2: walk back up, read every index in each window
        for (int k = 0; k < NW; k++) begin
            for (int i = 0; i < 16; i++) rd(2 * i, 2 * i + 1, "R6");
            cyc(0, 1, 0, 0, 0, 32'h0, 8, 24, '0, "R5");
        end
        rd(3, 5, "R2");

        // R7: save into invalid window
        cyc(1, 0, 0, 0, 0, 32'h0, 1, 2, NW'(1) << ((mcwp + NW - 1) % NW), "R7");
        // R9: trap into invalid window, and save+restore blocked downward
        cyc(0, 0, 1, 0, 0, 32'h0, 1, 2, NW'(1) << ((mcwp + NW - 1) % NW), "R9");
        cyc(1, 1, 0, 0, 0, 32'h0, 1, 2, NW'(1) << ((mcwp + NW - 1) % NW), "R9");
        // R8: restore into invalid window
        cyc(0, 1, 0, 0, 0, 32'h0, 1, 2, NW'(1) << ((mcwp + 1) % NW), "R8");
        // R9: save with restore moves down; trap moves down
        cyc(1, 1, 0, 0, 0, 32'h0, 9, 25, '0, "R9");
        cyc(0, 0, 1, 0, 0, 32'h0, 9, 25, '0, "R9");
        rd(25, 17, "R9");

        // Mixed pseudo-random traffic (R3)
        for (int n = 0; n < 600; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            cyc(lfsr[0] & lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5] & lfsr[6],
                lfsr[7], int'(lfsr[12:8]), {lfsr[15:0], lfsr[31:16]},
                int'(lfsr[17:13]), int'(lfsr[22:18]),
                (lfsr[23] ? NW'(lfsr[31:24]) : '0), "R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule